// File: doc/BRIEF.md
# Ownership-Tracked Shared Mailbox Window

This block is a 256-bit register window that a requesting function and a controlling function share. Both sides see it as eight 32-bit dwords, numbered 0 to 7. At any moment exactly one side owns the window, and only the owner's writes take effect. The requester fills the payload dwords. It then writes the last dword, which holds the control header, and that write passes ownership to the controller as a side effect. The controller reads the request and writes its response header into the last dword. Writing that dword with the owner bit clear gives the window back to the requester.

Bit 31 of the last dword always reports the current owner. While the requesting function is held in reset, its read port returns all ones at every address, and its writes have no effect. When the window is handed back, the block compares the response header with the request it latched earlier. It then raises a one-cycle verdict that says whether the response is well formed and reports success.

Top module: `mbox_aperture`

## Requirements
- R1: After reset the requester owns the window (dword 7 bit 31 reads 0), every dword reads 0 on both ports, and `req_wr_err`, `owner_ctl` and `resp_valid` are 0.
- R2: A requester write to dwords 0 to 6 while the requester owns the window is stored, is readable from both ports in the next cycle, and leaves ownership unchanged.
- R3: A requester write to dword 7 while the requester owns the window hands ownership to the controller. From the next cycle, `owner_ctl` is 1 and dword 7 reads with bit 31 set and bits 30:0 as written; bit 31 of the written data is ignored.
- R4: A requester write to any dword while the controller owns the window is ignored, and it sets `req_wr_err`. The flag stays set until block reset.
- R5: Controller writes to any dword while the requester owns the window are ignored and raise no error.
- R6: A controller write to dword 7 stores bits 30:0. If bit 31 of the written data is 0, ownership returns to the requester. If bit 31 is 1, the controller keeps the window.
- R7: Controller writes to dwords 0 to 6 while the controller owns the window are stored, do not change ownership, and are readable by the requester.
- R8: While `fn_in_reset` is 1, `req_rdata` is 0xFFFFFFFF at every address, and requester writes change neither contents, ownership nor `req_wr_err`. The controller port still reads the true contents.
- R9: In the cycle after a handback write, `resp_valid` is 1 for exactly one cycle. Header layout: type in bits 2:0, version in bits 5:3, direction in bit 7 (1 = response), status in bits 15:8, reset-function flag in bit 24, owner in bit 31. `resp_ok` is 1 only if all of the following hold: the response type equals the request type, the response version is not above the request version, the direction is 1, and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| fn_in_reset | input | 1 | Requesting function is held in reset |
| req_wr_en | input | 1 | Requester write strobe |
| req_addr | input | 3 | Requester dword index |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data (combinational) |
| req_wr_err | output | 1 | Sticky flag: requester wrote while not owner |
| ctl_wr_en | input | 1 | Controller write strobe |
| ctl_addr | input | 3 | Controller dword index |
| ctl_wdata | input | 32 | Controller write data |
| ctl_rdata | output | 32 | Controller read data (combinational) |
| owner_ctl | output | 1 | 1 while the controller owns the window |
| resp_valid | output | 1 | One-cycle pulse after a handback |
| resp_ok | output | 1 | Verdict on the response header, valid with resp_valid |

## Verification
A full request/response round trip is run with payload written from each side. The trip is checked against attempts from the side that does not own the window, which tells a correct ownership gate from one that only blocks the payload or only blocks dword 7. Handback headers are varied one field at a time: matching, lower version, higher version, wrong direction, and non-zero status. This separates each term of the response check. Reads and writes made during the function's reset tell the all-ones read mask apart from the stored contents, which the controller port still shows.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int HDR_TYPE_LSB  = 0;
    localparam int HDR_TYPE_W    = 3;
    localparam int HDR_VER_LSB   = 3;
    localparam int HDR_VER_W     = 3;
    localparam int HDR_DIR_BIT   = 7;
    localparam int HDR_STAT_LSB  = 8;
    localparam int HDR_STAT_W    = 8;

    typedef struct packed {
        logic owner;   // 1: controller owns the window
        logic err;     // sticky requester misuse flag
    } own_state_t;

    typedef struct packed {
        logic [HDR_TYPE_W-1:0] req_type;
        logic [HDR_VER_W-1:0]  req_ver;
        logic                  valid;
        logic                  ok;
    } chk_state_t;
endpackage

// File: rtl/mbox_owner.sv
module mbox_owner
    import mbox_pkg::*;
#(
    parameter int AW   = 3,
    parameter int LAST = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fn_rst,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic          ctl_wr,
    input  logic [AW-1:0] ctl_addr,
    input  logic          ctl_own_bit,
    output logic          owner_ctl,
    output logic          req_accept,
    output logic          ctl_accept,
    output logic          req_err
);
    own_state_t st_d, st_q;
    logic req_hits_last, ctl_hits_last;

    always_comb begin
        st_d          = st_q;
        req_hits_last = (req_addr == AW'(LAST));
        ctl_hits_last = (ctl_addr == AW'(LAST));
        req_accept    = req_wr && !fn_rst && !st_q.owner;
        ctl_accept    = ctl_wr && st_q.owner;
        if (req_wr && !fn_rst && st_q.owner) begin
            st_d.err = 1'b1;
        end
        if (req_accept && req_hits_last) begin
            st_d.owner = 1'b1;
        end else if (ctl_accept && ctl_hits_last && !ctl_own_bit) begin
            st_d.owner = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner_ctl = st_q.owner;
    assign req_err   = st_q.err;

    // Requester keeps the window unless it writes the header dword
    assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_ctl && !(req_wr && !fn_rst && req_addr == AW'(LAST))) |=> !owner_ctl);

    // Controller handback releases the window
    assert_handback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_ctl && ctl_wr && ctl_addr == AW'(LAST) && !ctl_own_bit) |=> !owner_ctl);

    // Controller keeps the window when it writes the header with owner set
    assert_keep_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_ctl && !(ctl_wr && ctl_addr == AW'(LAST) && !ctl_own_bit)) |=> owner_ctl);

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> req_err);

    assert_one_writer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && ctl_accept));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int AW        = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_we,
    input  logic [AW-1:0]                     req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic                              ctl_we,
    input  logic [AW-1:0]                     ctl_addr,
    input  logic [DATA_W-1:0]                 ctl_wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
    localparam int LAST = NUM_WORDS - 1;

    logic [NUM_WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (req_we) begin
            mem_d[req_addr] = req_wdata;
        end else if (ctl_we) begin
            mem_d[ctl_addr] = ctl_wdata;
        end
        // owner bit lives in the ownership tracker, never in storage
        mem_d[LAST][DATA_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign words = mem_q;

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word_chk
        // A dword not targeted by an accepted write keeps its value
        assert_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !((req_we && req_addr == AW'(gi)) || (ctl_we && ctl_addr == AW'(gi)))
            |=> $stable(words[gi]));
    end
endmodule

// File: rtl/mbox_resp_check.sv
module mbox_resp_check
    import mbox_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_hdr_we,
    input  logic [HDR_TYPE_W-1:0] req_type,
    input  logic [HDR_VER_W-1:0]  req_ver,
    input  logic                  rsp_we,
    input  logic [HDR_TYPE_W-1:0] rsp_type,
    input  logic [HDR_VER_W-1:0]  rsp_ver,
    input  logic                  rsp_dir,
    input  logic [HDR_STAT_W-1:0] rsp_status,
    output logic                  resp_valid,
    output logic                  resp_ok
);
    chk_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ok    = 1'b0;
        if (req_hdr_we) begin
            st_d.req_type = req_type;
            st_d.req_ver  = req_ver;
        end
        if (rsp_we) begin
            st_d.valid = 1'b1;
            st_d.ok    = (rsp_type == st_q.req_type) && (rsp_ver <= st_q.req_ver)
                         && rsp_dir && (rsp_status == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.valid;
    assign resp_ok    = st_q.ok;

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_bad_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_we && rsp_status != '0) |=> !resp_ok);
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
    import mbox_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fn_in_reset,
    input  logic                          req_wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0]  req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic [DATA_W-1:0]             req_rdata,
    output logic                          req_wr_err,
    input  logic                          ctl_wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0]  ctl_addr,
    input  logic [DATA_W-1:0]             ctl_wdata,
    output logic [DATA_W-1:0]             ctl_rdata,
    output logic                          owner_ctl,
    output logic                          resp_valid,
    output logic                          resp_ok
);
    localparam int AW      = $clog2(NUM_WORDS);
    localparam int LAST    = NUM_WORDS - 1;
    localparam int OWN_BIT = DATA_W - 1;

    logic req_accept, ctl_accept;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words, view;
    logic req_hdr_we, rsp_we;

    mbox_owner #(.AW(AW), .LAST(LAST)) u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .fn_rst     (fn_in_reset),
        .req_wr     (req_wr_en),
        .req_addr   (req_addr),
        .ctl_wr     (ctl_wr_en),
        .ctl_addr   (ctl_addr),
        .ctl_own_bit(ctl_wdata[OWN_BIT]),
        .owner_ctl  (owner_ctl),
        .req_accept (req_accept),
        .ctl_accept (ctl_accept),
        .req_err    (req_wr_err)
    );

    mbox_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_we   (req_accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .ctl_we   (ctl_accept),
        .ctl_addr (ctl_addr),
        .ctl_wdata(ctl_wdata),
        .words    (words)
    );

    assign req_hdr_we = req_accept && (req_addr == AW'(LAST));
    assign rsp_we     = ctl_accept && (ctl_addr == AW'(LAST)) && !ctl_wdata[OWN_BIT];

    mbox_resp_check u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hdr_we(req_hdr_we),
        .req_type  (req_wdata[HDR_TYPE_LSB +: HDR_TYPE_W]),
        .req_ver   (req_wdata[HDR_VER_LSB +: HDR_VER_W]),
        .rsp_we    (rsp_we),
        .rsp_type  (ctl_wdata[HDR_TYPE_LSB +: HDR_TYPE_W]),
        .rsp_ver   (ctl_wdata[HDR_VER_LSB +: HDR_VER_W]),
        .rsp_dir   (ctl_wdata[HDR_DIR_BIT]),
        .rsp_status(ctl_wdata[HDR_STAT_LSB +: HDR_STAT_W]),
        .resp_valid(resp_valid),
        .resp_ok   (resp_ok)
    );

    always_comb begin
        view                = words;
        view[LAST][OWN_BIT] = owner_ctl;
        req_rdata           = fn_in_reset ? '1 : view[req_addr];
        ctl_rdata           = view[ctl_addr];
    end

    // Writes during function reset leave ownership and the error flag alone
    assert_rst_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_in_reset && !ctl_wr_en) |=> ($stable(owner_ctl) && $stable(req_wr_err)));

    // A new request header always hands the window to the controller
    assert_request_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_ctl && !fn_in_reset && req_wr_en && req_addr == AW'(LAST)) |=> owner_ctl);
endmodule

// File: tb/mbox_aperture_bench.sv
module mbox_aperture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fn_in_reset = 1'b0;
    logic        req_wr_en = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        req_wr_err;
    logic        ctl_wr_en = 1'b0;
    logic [2:0]  ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        owner_ctl;
    logic        resp_valid;
    logic        resp_ok;

    always #4 clk = ~clk;

    mbox_aperture u_mbox_aperture (
        .clk(clk), .rst_n(rst_n), .fn_in_reset(fn_in_reset),
        .req_wr_en(req_wr_en), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .req_wr_err(req_wr_err),
        .ctl_wr_en(ctl_wr_en), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .owner_ctl(owner_ctl),
        .resp_valid(resp_valid), .resp_ok(resp_ok)
    );

    typedef enum int {K_REQ, K_CTL, K_ERR, K_OWN, K_VAL, K_OK} kind_t;
    typedef struct {
        kind_t       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;

    // Monitor: pops each expected item and compares it with the port
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_REQ:   act = req_rdata;
                    K_CTL:   act = ctl_rdata;
                    K_ERR:   act = {31'd0, req_wr_err};
                    K_OWN:   act = {31'd0, owner_ctl};
                    K_VAL:   act = {31'd0, resp_valid};
                    default: act = {31'd0, resp_ok};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic expect_item(kind_t k, logic [2:0] a, logic [31:0] e, string tag);
        item_t it;
        if (k == K_REQ) req_addr = a;
        if (k == K_CTL) ctl_addr = a;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
        #1;
        -> sample_ev;
        #1;
    endtask

    task automatic wr_req(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        req_wr_en = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_wr_en = 1'b0;
    endtask

    task automatic wr_ctl(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    // One complete exchange; verdict is sampled in the pulse cycle
    task automatic exchange(logic [31:0] rq, logic [31:0] rs, logic ok, string tag);
        wr_req(3'd7, rq);
        expect_item(K_OWN, 0, 1, {"R3 ", tag});
        wr_ctl(3'd7, rs);
        expect_item(K_VAL, 0, 1, {"R9 valid ", tag});
        expect_item(K_OK,  0, {31'd0, ok}, {"R9 ok ", tag});
        expect_item(K_OWN, 0, 0, {"R6 handback ", tag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_item(K_REQ, 3'd0, 32'h0, "R1 dword0");
        expect_item(K_REQ, 3'd7, 32'h0, "R1 dword7");
        expect_item(K_OWN, 0, 0, "R1 owner");
        expect_item(K_ERR, 0, 0, "R1 err");
        expect_item(K_VAL, 0, 0, "R1 resp_valid");

        // R2 payload from requester
        wr_req(3'd0, 32'hA5A5_5A5A);
        wr_req(3'd6, 32'h0BAD_F00D);
        expect_item(K_REQ, 3'd0, 32'hA5A5_5A5A, "R2 req read dw0");
        expect_item(K_CTL, 3'd6, 32'h0BAD_F00D, "R2 ctl read dw6");
        expect_item(K_OWN, 0, 0, "R2 owner unchanged");

        // R5 controller ignored while requester owns
        wr_ctl(3'd0, 32'hDEAD_BEEF);
        wr_ctl(3'd7, 32'h0000_0089);
        expect_item(K_REQ, 3'd0, 32'hA5A5_5A5A, "R5 dw0 kept");
        expect_item(K_CTL, 3'd7, 32'h0, "R5 dw7 kept");
        expect_item(K_ERR, 0, 0, "R5 no error");
        expect_item(K_VAL, 0, 0, "R5 no verdict");

        // R3 request header: type 1, version 1, reset flag
        wr_req(3'd7, 32'h0100_0009);
        expect_item(K_OWN, 0, 1, "R3 owner to controller");
        expect_item(K_REQ, 3'd7, 32'h8100_0009, "R3 req read dw7");
        expect_item(K_CTL, 3'd7, 32'h8100_0009, "R3 ctl read dw7");

        // R4 requester write while controller owns
        wr_req(3'd2, 32'h5555_5555);
        expect_item(K_CTL, 3'd2, 32'h0, "R4 dw2 unchanged");
        expect_item(K_ERR, 0, 1, "R4 err set");

        // R7 controller payload
        wr_ctl(3'd1, 32'h1234_5678);
        expect_item(K_REQ, 3'd1, 32'h1234_5678, "R7 req sees ctl data");
        expect_item(K_OWN, 0, 1, "R7 owner unchanged");

        // R6 header write with owner bit set keeps the window
        wr_ctl(3'd7, 32'h8000_0089);
        expect_item(K_OWN, 0, 1, "R6 owner kept");
        expect_item(K_CTL, 3'd7, 32'h8000_0089, "R6 header stored");
        expect_item(K_VAL, 0, 0, "R6 no verdict");

        // R6/R9 good handback
        wr_ctl(3'd7, 32'h0000_0089);
        expect_item(K_VAL, 0, 1, "R9 valid");
        expect_item(K_OK, 0, 1, "R9 ok match");
        expect_item(K_OWN, 0, 0, "R6 handback");
        expect_item(K_REQ, 3'd7, 32'h0000_0089, "R6 response readable");
        @(negedge clk);
        expect_item(K_VAL, 0, 0, "R9 single pulse");
        expect_item(K_ERR, 0, 1, "R4 err sticky");

        // R9 header variants
        exchange(32'h0000_000A, 32'h0000_0182, 1'b0, "nonzero status");
        exchange(32'h0000_0009, 32'h0000_0091, 1'b0, "higher version");
        exchange(32'h0000_0011, 32'h0000_0089, 1'b1, "lower version");
        exchange(32'h0000_0009, 32'h0000_0009, 1'b0, "direction 0");
        exchange(32'h0000_0009, 32'h0000_008A, 1'b0, "type mismatch");

        // R8 function reset
        @(negedge clk);
        fn_in_reset = 1'b1;
        expect_item(K_REQ, 3'd1, 32'hFFFF_FFFF, "R8 masked dw1");
        expect_item(K_REQ, 3'd7, 32'hFFFF_FFFF, "R8 masked dw7");
        expect_item(K_CTL, 3'd1, 32'h1234_5678, "R8 ctl true dw1");
        wr_req(3'd1, 32'hFFFF_0000);
        wr_req(3'd7, 32'h0000_0001);
        expect_item(K_OWN, 0, 0, "R8 owner unchanged");
        expect_item(K_CTL, 3'd1, 32'h1234_5678, "R8 write ignored");
        fn_in_reset = 1'b0;
        expect_item(K_REQ, 3'd1, 32'h1234_5678, "R8 unmasked dw1");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule